// File: doc/BRIEF.md
# SPI Master Byte Shifter

This block runs one full-duplex SPI exchange per start command. Eight bits leave on the data-out line while eight bits arrive on the data-in line during the same transfer. Static configuration inputs set the clock polarity, the clock phase, the bit order and one of four clock rates. A one-cycle write strobe hands over the byte to send and starts the transfer. When the exchange ends, the block holds the received byte, raises a completion flag and, if interrupts are enabled, an interrupt line. The completion flag stays up until a read strobe clears it.

A transfer lasts seventeen half-periods of the serial clock. Sixteen of them carry the sixteen clock edges. The last one keeps the select line low while the clock sits at its idle level. The block samples polarity, phase, rate and bit order when it accepts a write and holds them until the transfer ends.

Top module: `spi_master_core`

## Requirements
- R1: When `cfg_enable`=1, the block is idle and `wr_stb`=1, the write is accepted at that clock edge. After the edge `busy`=1 and `ss_n`=0.
- R2: A write strobe is ignored while `cfg_enable`=0 or while `busy`=1. It starts nothing and does not change the transfer in progress.
- R3: `cfg_rate` selects the serial clock. Code 0 gives sys/4, 1 gives sys/16, 2 gives sys/64 and 3 gives sys/128. Clock edge n of a transfer (n=1..16) appears at the clock edge n·H after acceptance, where H is half the divisor.
- R4: With `cfg_lsb_first`=0 the word is sent and received most significant bit first. With 1 it goes least significant bit first.
- R5: Transmit and receive happen in the same transfer. At completion `rd_data` holds the eight bits captured from `miso`, placed in the chosen bit order.
- R6: With `cfg_cpha`=0, `mosi` shows the first bit from acceptance, `miso` is captured on leading edges and `mosi` advances on trailing edges. With `cfg_cpha`=1, `mosi` advances on leading edges and `miso` is captured on trailing edges.
- R7: While the block is idle, `sck` rests at the level of `cfg_cpol` one cycle later. A transfer produces exactly 16 `sck` toggles and leaves `sck` at the idle level.
- R8: `ss_n` is low for exactly 17·H cycles from acceptance, and high at all other times including reset.
- R9: `done_flag` sets when `ss_n` returns high, at the same edge that loads `rd_data`. It clears on `rd_stb` and is 0 after reset.
- R10: `irq` is 1 exactly when `done_flag`=1 and `cfg_irq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows writes to start a transfer |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_lsb_first | input | 1 | Bit order, 1 = least significant first |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | 0 = capture on leading edge, 1 = on trailing edge |
| cfg_rate | input | 2 | Clock divisor code |
| wr_stb | input | 1 | Start strobe carrying wr_data |
| wr_data | input | DATA_W | Word to transmit |
| rd_stb | input | 1 | Read acknowledge, clears done_flag |
| rd_data | output | DATA_W | Last received word |
| done_flag | output | 1 | Transfer complete, not yet read |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench runs a slave model that changes `miso` on the bench's own bit index. If the block captures on the wrong edge for a given phase, the received byte comes out shifted by one position or taken from the wrong bit. Each rate code is run so that a wrong divisor shows up as early or late clock edges. Writes are issued while the block is disabled and in the middle of a transfer; a design that does not ignore them would restart the exchange or corrupt the outgoing bits. The bench also checks the tail half-period, so a design that releases select on the last clock edge, or that leaves the clock off its idle level, is caught.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;

  localparam int TICK_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } xfer_st_t;

  // Half of the sck period, in system clocks, for each rate code.
  function automatic logic [TICK_W-1:0] half_ticks(input logic [1:0] code);
    case (code)
      2'b00:   return TICK_W'(2);
      2'b01:   return TICK_W'(8);
      2'b10:   return TICK_W'(32);
      default: return TICK_W'(64);
    endcase
  endfunction

endpackage

// File: rtl/spi_m_divider.sv
module spi_m_divider
  import spi_m_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick_evt
);

  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] limit;

  assign limit    = half_ticks(rate);
  assign tick_evt = run && (cnt == limit - TICK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (tick_evt) cnt <= '0;
    else if (run)      cnt <= cnt + TICK_W'(1);
  end

  // R3: the half-period counter never passes its limit
  assert_tick_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/spi_m_edgectl.sv
module spi_m_edgectl #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic idle,
  input  logic tick_evt,
  input  logic cpol_in,
  output logic sck,
  output logic lead_evt,
  output logic trail_evt,
  output logic first_evt,
  output logic last_evt
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0] ecnt;
  logic          step;

  assign step      = active && tick_evt;
  assign lead_evt  = step && !ecnt[0];
  assign trail_evt = step &&  ecnt[0];
  assign first_evt = step && (ecnt == '0);
  assign last_evt  = step && (ecnt == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck  <= 1'b0;
      ecnt <= '0;
    end else if (start) begin
      sck  <= cpol_in;
      ecnt <= '0;
    end else if (step) begin
      sck  <= ~sck;
      ecnt <= ecnt + EW'(1);
    end else if (idle) begin
      sck  <= cpol_in;
    end
  end

  // R7: during a transfer sck moves only on a divider event
  assert_sck_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !idle && !start) |=> $stable(sck));

endmodule

// File: rtl/spi_m_shifter.sv
module spi_m_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              lsb_first,
  input  logic              adv,
  input  logic              cap,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] txsr;
  logic [DATA_W-1:0] rxsr;
  logic              order_lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr      <= '0;
      rxsr      <= '0;
      order_lsb <= 1'b0;
    end else if (load) begin
      txsr      <= lsb_first ? load_word : flip(load_word);
      rxsr      <= '0;
      order_lsb <= lsb_first;
    end else begin
      if (adv) txsr <= {1'b0, txsr[DATA_W-1:1]};
      if (cap) rxsr <= {miso, rxsr[DATA_W-1:1]};
    end
  end

  assign mosi    = txsr[0];
  assign rx_word = order_lsb ? rxsr : flip(rxsr);

  // R6: a single edge never both advances and captures
  assert_adv_cap_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && cap));

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_m_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_irq_en,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_rate,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              done_flag,
  output logic              irq,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);

  xfer_st_t          state;
  logic [1:0]        lat_rate;
  logic              lat_cpha;
  logic              accept;
  logic              tick_evt;
  logic              lead_evt, trail_evt, first_evt, last_evt;
  logic              adv, cap, finish;
  logic [DATA_W-1:0] rx_word;

  assign accept = wr_stb && cfg_enable && (state == ST_IDLE);
  assign finish = (state == ST_TAIL) && tick_evt;
  assign adv    = lat_cpha ? (lead_evt && !first_evt) : (trail_evt && !last_evt);
  assign cap    = lat_cpha ? trail_evt : lead_evt;
  assign busy   = (state != ST_IDLE);
  assign irq    = done_flag && cfg_irq_en;

  spi_m_divider u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .run      (busy),
    .rate     (lat_rate),
    .tick_evt (tick_evt)
  );

  spi_m_edgectl #(.DATA_W(DATA_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .active    (state == ST_RUN),
    .idle      (state == ST_IDLE),
    .tick_evt  (tick_evt),
    .cpol_in   (cfg_cpol),
    .sck       (sck),
    .lead_evt  (lead_evt),
    .trail_evt (trail_evt),
    .first_evt (first_evt),
    .last_evt  (last_evt)
  );

  spi_m_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (wr_data),
    .lsb_first (cfg_lsb_first),
    .adv       (adv),
    .cap       (cap),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ss_n     <= 1'b1;
      lat_rate <= 2'b00;
      lat_cpha <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          ss_n     <= 1'b0;
          lat_rate <= cfg_rate;
          lat_cpha <= cfg_cpha;
        end
        ST_RUN:  if (last_evt) state <= ST_TAIL;
        ST_TAIL: if (tick_evt) begin
          state <= ST_IDLE;
          ss_n  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      rd_data   <= '0;
    end else if (finish) begin
      done_flag <= 1'b1;
      rd_data   <= rx_word;
    end else if (rd_stb) begin
      done_flag <= 1'b0;
    end
  end

  // R1: select only drops in answer to an enabled write
  assert_select_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(wr_stb && cfg_enable));

  // R2: a write during a transfer leaves the sampled settings alone
  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> ($stable(lat_rate) && $stable(lat_cpha)));

  // R7: idle clock level follows polarity
  assert_sck_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(rst_n)) |-> (sck == $past(cfg_cpol)));

  // R9: completion appears together with select release
  assert_done_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (ss_n && $past(!ss_n)));

endmodule

// File: tb/spi_master_core_test.sv
module spi_master_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_irq_en = 1'b0, cfg_lsb_first = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [1:0] cfg_rate = 2'b00;
  logic       wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       done_flag, irq, busy, sck, mosi, ss_n;
  logic       miso = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_master_core #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_rate(cfg_rate), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .done_flag(done_flag), .irq(irq), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int half_of(input logic [1:0] code);
    int divisor;
    divisor = (code == 2'd3) ? 128 : (4 << (2 * code));
    return divisor / 2;
  endfunction

  // bit position on the wire after t clock toggles
  function automatic int wire_idx(input int t, input logic pha);
    int k;
    if (!pha) k = t / 2;
    else      k = (t == 0) ? 0 : (t - 1) / 2;
    return (k > 7) ? 7 : k;
  endfunction

  function automatic logic wire_bit(input logic [7:0] w, input int j, input logic lsb);
    return lsb ? w[j] : w[7 - j];
  endfunction

  // behavioural reference
  bit         m_busy;
  int         m_c, m_h;
  logic       m_lsb, m_pha, m_pol, m_idle_sck, m_done;
  logic [7:0] m_tx, m_rd, m_slave;
  logic [7:0] slave_byte = 8'h00;
  logic       p_wr, p_en, p_rd, p_lsb, p_pol, p_pha;
  logic [1:0] p_rate;
  logic [7:0] p_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_c = 0; m_h = 2; m_done = 0; m_rd = 8'h00; m_idle_sck = 1'b0;
      m_lsb = 0; m_pha = 0; m_pol = 0; m_tx = 0; m_slave = 0;
    end else begin
      bit was_busy, set_now;
      int t;
      was_busy = m_busy;
      set_now = 0;
      if (m_busy) begin
        m_c++;
        if (m_c == 17 * m_h) begin
          m_busy = 0; m_done = 1; set_now = 1; m_rd = m_slave; m_idle_sck = m_pol;
        end
      end else if (p_wr && p_en) begin
        m_busy = 1; m_c = 0; m_h = half_of(p_rate);
        m_lsb = p_lsb; m_pha = p_pha; m_pol = p_pol; m_tx = p_data; m_slave = slave_byte;
      end
      if (!was_busy) m_idle_sck = p_pol;
      if (p_rd && !set_now) m_done = 0;

      check("R8 ss_n", ss_n, !m_busy);
      check("R1 busy", busy, m_busy);
      if (m_busy) begin
        t = m_c / m_h;
        if (t > 16) t = 16;
        check("R3 R7 sck", sck, m_pol ^ t[0]);
        check("R2 R4 R6 mosi", mosi, wire_bit(m_tx, wire_idx(t, m_pha), m_lsb));
        miso = wire_bit(m_slave, wire_idx(t, m_pha), m_lsb);
      end else begin
        check("R7 idle sck", sck, m_idle_sck);
        miso = 1'b1;
      end
      check("R9 done", done_flag, m_done);
      check("R10 irq", irq, m_done & cfg_irq_en);
      check("R5 rd_data", rd_data, m_rd);
    end
    p_wr = wr_stb; p_en = cfg_enable; p_rd = rd_stb; p_lsb = cfg_lsb_first;
    p_pol = cfg_cpol; p_pha = cfg_cpha; p_rate = cfg_rate; p_data = wr_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step_after_edge();
    @(posedge clk); #2;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    step_after_edge();
    wr_stb = 1'b0;
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    step_after_edge();
    rd_stb = 1'b0;
    check("R9 cleared by read", done_flag, 0);
  endtask

  task automatic xfer(input logic lsb, input logic pol, input logic pha,
                      input logic [1:0] rate, input logic [7:0] d, input logic [7:0] s);
    cfg_lsb_first = lsb; cfg_cpol = pol; cfg_cpha = pha; cfg_rate = rate;
    step_after_edge();
    step_after_edge();
    check("R7 idle level before start", sck, pol);
    slave_byte = s;
    pulse_wr(d);
    check("R1 select low", ss_n, 0);
    repeat (17 * half_of(rate)) step_after_edge();
    check("R8 select released", ss_n, 1);
    check("R5 received word", rd_data, s);
    check("R9 done set", done_flag, 1);
  endtask

  initial begin
    repeat (3) step_after_edge();
    check("R8 reset ss_n", ss_n, 1);
    check("R1 reset busy", busy, 0);
    check("R9 reset done", done_flag, 0);
    check("R10 reset irq", irq, 0);
    rst_n = 1'b1;
    step_after_edge();

    // disabled write is ignored
    cfg_enable = 1'b0;
    pulse_wr(8'h77);
    step_after_edge();
    check("R2 disabled write", ss_n, 1);
    check("R2 disabled busy", busy, 0);
    cfg_enable = 1'b1;

    xfer(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C); do_read();
    xfer(1'b1, 1'b1, 1'b1, 2'd1, 8'h81, 8'hE2); do_read();
    xfer(1'b0, 1'b0, 1'b1, 2'd2, 8'h5A, 8'h96); do_read();
    xfer(1'b1, 1'b1, 1'b0, 2'd3, 8'h0F, 8'hC1); do_read();

    // interrupt gating
    cfg_irq_en = 1'b1;
    xfer(1'b0, 1'b1, 1'b0, 2'd0, 8'hFF, 8'h01);
    check("R10 irq with enable", irq, 1);
    cfg_irq_en = 1'b0;
    #1 check("R10 irq masked", irq, 0);
    check("R9 flag kept when masked", done_flag, 1);
    do_read();

    // write during a transfer is ignored
    cfg_lsb_first = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_rate = 2'd1;
    slave_byte = 8'h6B;
    pulse_wr(8'hC3);
    repeat (20) step_after_edge();
    cfg_rate = 2'd0;
    pulse_wr(8'h00);
    check("R2 busy write", busy, 1);
    repeat (17 * 8 - 21) step_after_edge();
    check("R2 transfer unchanged", rd_data, 8'h6B);
    check("R8 release after busy write", ss_n, 1);
    do_read();

    // back-to-back without reading
    xfer(1'b0, 1'b0, 1'b0, 2'd0, 8'h12, 8'h34);
    xfer(1'b0, 1'b0, 1'b0, 2'd0, 8'h56, 8'h78);
    do_read();

    repeat (4) step_after_edge();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule